// File: doc/BRIEF.md
# Delta-Sigma Modulator Clock and Bit Capture Interface

This block lets a chip clock an external second-order delta-sigma modulator from the system clock, and collect the 1-bit stream that the modulator returns. The system clock is divided by an even ratio to make a conversion clock with a 50% duty cycle. This conversion clock runs at twice the wanted modulator sampling rate. The two mode-select pins of the modulator are held high at all times. That choice selects the external-clock mode, in which the modulator's internal oscillator is switched off.

The returned data line is asynchronous to the system clock. It passes through a flop synchronizer. The bit is taken only on every other falling edge of the conversion clock, which gives one bit per modulator period. Each accepted bit is presented with a one-cycle valid strobe in the system clock domain, for a downstream decimation filter. The capture is delayed by the synchronizer depth, so that the bit delivered is the line value at the moment of that falling edge.

Top module: `dsm_clk_capture`

## Requirements
- R1: Both bits of `mode_sel_out` are 1 in every cycle, reset included (encoding 2'b11 = external conversion clock).
- R2: In the cycle after any clock edge with `rst` high, `mclk_out` is 0, `sample_valid` is 0 and `sample_bit` is 0.
- R3: `mclk_out` is high for exactly DIV_RATIO/2 system cycles and low for exactly DIV_RATIO/2 system cycles, so its period is DIV_RATIO cycles.
- R4: After reset is released, with the first active edge counted as edge 1, `mclk_out` is low after edges 1 to DIV_RATIO/2-1. It is high from edge DIV_RATIO/2 onwards, and first falls at edge DIV_RATIO.
- R5: `sample_valid` is a single-cycle pulse. Consecutive pulses are exactly 2*DIV_RATIO system cycles apart, which is one pulse per two conversion-clock periods.
- R6: The falling edges of `mclk_out` after reset are numbered 1, 2, 3 and so on. Only the even-numbered edges capture a bit. The first `sample_valid` is high after edge 2*DIV_RATIO+SYNC_STAGES.
- R7: When `sample_valid` is high, `sample_bit` equals the value that `mod_data_in` held just before the system clock edge that lowered `mclk_out` on a capturing falling edge.
- R8: Values of `mod_data_in` at any other edge have no effect. `sample_bit` keeps its value in every cycle in which `sample_valid` is low.
- R9: A reset asserted at any conversion-clock phase restarts the sequence, and after release R4 and R6 hold again from edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_data_in | input | 1 | Asynchronous 1-bit data stream from the modulator |
| mclk_out | output | 1 | Conversion clock to the modulator, system clock divided by DIV_RATIO |
| mode_sel_out | output | 2 | Mode-select pins, both driven high |
| sample_bit | output | 1 | Last captured modulator bit |
| sample_valid | output | 1 | One-cycle strobe marking a new `sample_bit` |

## Verification
The conversion clock is a registered output, so the level for edge k depends only on k modulo DIV_RATIO and is visible right after edge k. A captured bit follows its capturing edge by SYNC_STAGES edges, since the synchronizer stages and the alignment delay each add one register. The bench counts edges from reset release, and works out from that count the conversion-clock level, the cycles in which the strobe is due, and which stimulus cycle a bit comes from. It reads every output on the falling system-clock edge after the rising edge it is checking. Around each capturing edge it drives the complement of the expected bit, so a bit taken one cycle early or late shows up as a wrong value.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Mode-select encoding that puts the modulator into external-clock mode.
    localparam logic [1:0] MODE_EXT_CLK = 2'b11;

    // Which falling edge of the conversion clock is the next one to use.
    typedef enum logic {
        EDGE_SKIP = 1'b0,
        EDGE_TAKE = 1'b1
    } edge_sel_e;

    // One captured modulator bit together with its strobe.
    typedef struct packed {
        logic valid;
        logic bit_val;
    } sample_t;

    // Width of a counter that has to hold the values 0 .. n-1 (at least 1 bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((32'd1 << w) < n) begin
            w = w + 1;
        end
        return w;
    endfunction

    // The conversion clock is high in the second half of its phase range.
    function automatic logic phase_is_high(input int unsigned ph, input int unsigned half);
        return (ph >= half);
    endfunction

endpackage

// File: rtl/dsm_clk_gen.sv
module dsm_clk_gen
    import dsm_pkg::*;
#(
    parameter int unsigned DIV_RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    output logic mclk,
    output logic fall_evt
);
    localparam int unsigned HALF = DIV_RATIO / 2;
    localparam int unsigned PH_W = cnt_width(DIV_RATIO);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_RATIO - 1);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_d;
    logic            wrap;
    logic            mclk_q;

    assign wrap = (ph_q == PH_LAST);
    assign ph_d = wrap ? '0 : ph_q + 1'b1;

    // Phase counter and the conversion clock are updated together, so the clock
    // level always matches the phase held in the counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            mclk_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            mclk_q <= phase_is_high(int'(ph_d), HALF);
        end
    end

    assign mclk = mclk_q;
    // The edge that wraps the phase lowers the conversion clock.
    assign fall_evt = wrap;

endmodule

// File: rtl/dsm_bit_sync.sv
module dsm_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= {st_q[STAGES-2:0], din};
        end
    end

    assign dout = st_q[STAGES-1];

endmodule

// File: rtl/dsm_edge_capture.sv
module dsm_edge_capture
    import dsm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fall_evt,
    input  logic    sync_bit,
    output sample_t smp
);
    edge_sel_e              alt_q;
    logic                   take;
    logic [SYNC_STAGES-1:0] dly_q;
    sample_t                smp_q;

    // Every second falling edge is a capture edge; the first one after reset is skipped.
    assign take = fall_evt && (alt_q == EDGE_TAKE);

    always_ff @(posedge clk) begin
        if (rst) begin
            alt_q <= EDGE_SKIP;
        end else if (fall_evt) begin
            alt_q <= (alt_q == EDGE_TAKE) ? EDGE_SKIP : EDGE_TAKE;
        end
    end

    // Delay the capture request by the synchronizer depth, so that the bit taken
    // is the line value at the capturing edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else begin
            dly_q[0] <= take;
            for (int i = 1; i < int'(SYNC_STAGES); i++) begin
                dly_q[i] <= dly_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
        end else begin
            smp_q.valid <= dly_q[SYNC_STAGES-1];
            if (dly_q[SYNC_STAGES-1]) begin
                smp_q.bit_val <= sync_bit;
            end
        end
    end

    assign smp = smp_q;

endmodule

// File: rtl/dsm_clk_capture.sv
module dsm_clk_capture
    import dsm_pkg::*;
#(
    parameter int unsigned DIV_RATIO   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mod_data_in,
    output logic       mclk_out,
    output logic [1:0] mode_sel_out,
    output logic       sample_bit,
    output logic       sample_valid
);
    logic    fall_evt;
    logic    sync_bit;
    sample_t smp;

    dsm_clk_gen #(
        .DIV_RATIO(DIV_RATIO)
    ) u_clk_gen (
        .clk      (clk),
        .rst      (rst),
        .mclk     (mclk_out),
        .fall_evt (fall_evt)
    );

    dsm_bit_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (mod_data_in),
        .dout (sync_bit)
    );

    dsm_edge_capture #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .fall_evt (fall_evt),
        .sync_bit (sync_bit),
        .smp      (smp)
    );

    assign mode_sel_out = MODE_EXT_CLK;
    assign sample_bit   = smp.bit_val;
    assign sample_valid = smp.valid;

endmodule

// File: rtl/dsm_clk_capture_chk.sv
module dsm_clk_capture_chk #(
    parameter int unsigned DIV_RATIO   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       mclk_out,
    input logic [1:0] mode_sel_out,
    input logic       sample_bit,
    input logic       sample_valid
);
    localparam int HALF = int'(DIV_RATIO / 2);
    localparam int GAP  = int'(2 * DIV_RATIO);
    localparam int FIRST_GAP = GAP + int'(SYNC_STAGES);

    logic rst_d = 1'b0;
    logic mclk_prev;
    int   run_cnt;
    int   gap_cnt;
    logic seen_pulse;

    // R2: outputs are quiet in the cycle after a reset edge
    always @(posedge clk) begin
        if (rst_d) begin
            assert_reset_quiet_R2: assert (!mclk_out && !sample_valid && !sample_bit)
                else $error("reset did not clear the outputs");
        end
        rst_d <= rst;
    end

    assert_mode_high_R1: assert property (@(posedge clk) disable iff (rst)
        mode_sel_out == 2'b11);

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    assert_bit_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sample_bit) |-> sample_valid);

    // R3: every high and low run of the conversion clock lasts HALF cycles
    always @(posedge clk) begin
        if (rst) begin
            mclk_prev <= 1'b0;
            run_cnt   <= 0;
        end else if (mclk_out != mclk_prev) begin
            assert_duty_half_R3: assert (run_cnt == HALF)
                else $error("conversion clock run of %0d cycles", run_cnt);
            mclk_prev <= mclk_out;
            run_cnt   <= 1;
        end else begin
            run_cnt <= run_cnt + 1;
        end
    end

    // R5, R6: strobe spacing, and the delay from reset release to the first strobe
    always @(posedge clk) begin
        if (rst) begin
            gap_cnt    <= 0;
            seen_pulse <= 1'b0;
        end else if (sample_valid) begin
            if (seen_pulse) begin
                assert_strobe_gap_R5: assert (gap_cnt == GAP)
                    else $error("strobe gap %0d", gap_cnt);
            end else begin
                assert_first_strobe_R6: assert (gap_cnt == FIRST_GAP)
                    else $error("first strobe after %0d", gap_cnt);
            end
            seen_pulse <= 1'b1;
            gap_cnt    <= 1;
        end else begin
            gap_cnt <= gap_cnt + 1;
        end
    end

endmodule

bind dsm_clk_capture dsm_clk_capture_chk #(
    .DIV_RATIO   (DIV_RATIO),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mclk_out     (mclk_out),
    .mode_sel_out (mode_sel_out),
    .sample_bit   (sample_bit),
    .sample_valid (sample_valid)
);

// File: tb/dsm_clk_capture_test.sv
module dsm_clk_capture_test;
    localparam int DIV  = 16;
    localparam int SYNC = 2;
    localparam int HALF = DIV / 2;
    localparam int NV   = 8;
    // Each entry: bit 1 = level driven at the capture edge, bit 0 = expected sample_bit.
    localparam logic [1:0] VEC [NV] = '{2'b11, 2'b00, 2'b11, 2'b11,
                                        2'b00, 2'b00, 2'b11, 2'b00};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mod_data_in = 1'b0;
    logic       mclk_out;
    logic [1:0] mode_sel_out;
    logic       sample_bit;
    logic       sample_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dsm_clk_capture #(
        .DIV_RATIO   (DIV),
        .SYNC_STAGES (SYNC)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .mod_data_in  (mod_data_in),
        .mclk_out     (mclk_out),
        .mode_sel_out (mode_sel_out),
        .sample_bit   (sample_bit),
        .sample_valid (sample_valid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reset_checks(input string tag);
        chk("R2", {tag, " mclk in reset"}, int'(mclk_out), 0);
        chk("R2", {tag, " valid in reset"}, int'(sample_valid), 0);
        chk("R2", {tag, " bit in reset"}, int'(sample_bit), 0);
        chk("R1", {tag, " mode in reset"}, int'(mode_sel_out), 3);
    endtask

    // Walk the vector table from reset release; the edge index k starts at 1.
    task automatic walk(input logic inv, input string tag);
        logic exp_bit;
        exp_bit = 1'b0;
        for (int k = 1; k <= NV * 2 * DIV + 4; k++) begin
            int   j;
            logic d;
            logic exp_valid;
            j = (k - 1) / (2 * DIV);
            if (j < NV) begin
                d = (k == 2 * DIV * (j + 1)) ? (VEC[j][1] ^ inv) : ~(VEC[j][1] ^ inv);
            end else begin
                d = 1'b0;
            end
            mod_data_in = d;
            @(posedge clk);
            @(negedge clk);
            if (k <= DIV) begin
                chk("R4", {tag, " mclk start-up"}, int'(mclk_out), int'((k % DIV) >= HALF));
            end else begin
                chk("R3", {tag, " mclk level"}, int'(mclk_out), int'((k % DIV) >= HALF));
            end
            exp_valid = (k >= 2 * DIV + SYNC) && (((k - SYNC) % (2 * DIV)) == 0);
            if (k <= 2 * DIV + SYNC) begin
                chk("R6", {tag, " first strobe"}, int'(sample_valid), int'(exp_valid));
            end else begin
                chk("R5", {tag, " strobe"}, int'(sample_valid), int'(exp_valid));
            end
            if (exp_valid) begin
                exp_bit = VEC[(k - SYNC) / (2 * DIV) - 1][0] ^ inv;
                chk("R7", {tag, " captured bit"}, int'(sample_bit), int'(exp_bit));
            end else begin
                chk("R8", {tag, " bit hold"}, int'(sample_bit), int'(exp_bit));
            end
            chk("R1", {tag, " mode"}, int'(mode_sel_out), 3);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        reset_checks("power-up");
        rst = 1'b0;
        walk(1'b0, "pass1");

        // Run on to a phase where the conversion clock is high, then reset (R9).
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9", "mclk high before mid-run reset", int'(mclk_out), 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reset_checks("mid-run R9");
        @(posedge clk);
        @(negedge clk);
        reset_checks("mid-run R9 hold");
        rst = 1'b0;
        walk(1'b1, "pass2 after reset R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule